// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Interleaved Parity and Refill-on-Error

The block is a small direct-mapped read cache placed between a CPU read port and a slower backing memory. Each line holds a valid bit, a tag and one data word. When a line is filled, two check bits are computed from the word and stored with it. One check bit is the XOR of the data bits at even positions and the other is the XOR of the bits at odd positions. A fault that flips any single bit, or any two neighbouring bits, leaves at least one of the two check bits wrong, because neighbouring bits always fall into opposite groups.

A lookup compares the tag and re-checks both parity groups in the same cycle. A lookup whose tag matches but whose word fails the parity check is not returned to the CPU. The block treats it as a miss and fetches the word again from the backing memory. The fresh copy overwrites the damaged one, so the fault is repaired as a side effect of the refill.

Two counters separate ordinary misses from misses caused by parity errors. A fault-injection input can XOR a mask into a stored data word without touching its check bits. This lets the repair path be exercised from outside the block.

Top module: `parity_refill_cache`

## Requirements
- R1: After a synchronous active-high reset, every line is invalid, `cpu_ready`, `cpu_hit` and `mem_req` are low, and both counters read zero.
- R2: A lookup to an invalid line, or to a line whose tag differs, raises `mem_req` with `mem_addr` equal to the requested address. Both are held unchanged until `mem_valid` is seen, and `miss_count` increases by one.
- R3: During a refill `cpu_ready` stays low. In the cycle after `mem_valid`, `cpu_ready` is high for one cycle with `cpu_hit` low and `cpu_rdata` equal to the word the memory returned.
- R4: A lookup that hits raises `cpu_ready` and `cpu_hit` in the same cycle as `cpu_req`, returns the stored word and issues no memory request.
- R5: If the stored word of a tag-matching valid line has one bit flipped, the lookup is handled as a miss. The line is refilled, the correct word is returned with `cpu_hit` low, `perr_count` increases by one and `miss_count` is unchanged.
- R6: If two adjacent bits (positions 2k and 2k+1) of a stored word are flipped, the lookup is detected and handled exactly as in R5.
- R7: Two flipped bits in the same parity group (positions i and i+2) are not detected. The lookup hits and returns the corrupted word.
- R8: After an error-induced refill, a repeated lookup to the same address hits and returns the correct word.
- R9: Two addresses with the same index (the low `IDX_W` address bits) and different tags evict each other. Each alternating access misses.
- R10: When `flip_en` is high at a clock edge, `flip_mask` is XORed into the data word of line `flip_idx`, and the stored check bits, tag and valid bit are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU read request, held until `cpu_ready` |
| cpu_addr | input | AW | CPU word address, held with `cpu_req` |
| cpu_rdata | output | DW | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Request completed this cycle |
| cpu_hit | output | 1 | Completed request was served from the cache |
| mem_req | output | 1 | Refill request to backing memory |
| mem_addr | output | AW | Refill word address |
| mem_rdata | input | DW | Refill data from backing memory |
| mem_valid | input | 1 | Refill data valid (one cycle) |
| flip_en | input | 1 | Fault-injection strobe |
| flip_idx | input | IDX_W | Line index targeted by injection |
| flip_mask | input | DW | Bits to invert in the stored word |
| miss_count | output | CNT_W | Number of tag/valid misses |
| perr_count | output | CNT_W | Number of parity-error-induced misses |

## Verification
The assertions assume a well-behaved environment on three points:
- `mem_valid` comes only while `mem_req` is high, for a single cycle.
- The CPU holds `cpu_req` and `cpu_addr` steady until `cpu_ready`.
- Injection is never strobed in the same cycle as a refill write.

The memory model in the bench answers a request after a fixed latency and drops `mem_valid` on the next cycle. The read task deasserts its request right after it samples `cpu_ready`. Injections are issued only between completed reads, so none of them overlaps a fill.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RESP = 2'd2
    } fsm_e;

    typedef struct packed {
        logic odd;
        logic even;
    } par_t;

    function automatic logic par_mismatch(input par_t stored, input par_t fresh);
        return (stored.odd != fresh.odd) || (stored.even != fresh.even);
    endfunction

endpackage

// File: rtl/par_gen.sv
module par_gen #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   data,
    output cache_pkg::par_t par
);
    logic [DW-1:0] even_sel;

    for (genvar i = 0; i < DW; i++) begin : g_sel
        assign even_sel[i] = ((i % 2) == 0);
    end

    always_comb begin
        par.even = ^(data & even_sel);
        par.odd  = ^(data & ~even_sel);
    end
endmodule

// File: rtl/line_store.sv
module line_store #(
    parameter int IDX_W = 4,
    parameter int TW    = 8,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [TW-1:0]        rd_tag,
    output logic [DW-1:0]        rd_data,
    output cache_pkg::par_t      rd_par,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [TW-1:0]        wr_tag,
    input  logic [DW-1:0]        wr_data,
    input  cache_pkg::par_t      wr_par,
    input  logic                 flip_en,
    input  logic [IDX_W-1:0]     flip_idx,
    input  logic [DW-1:0]        flip_mask
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TW-1:0]     tag_q  [LINES];
    logic [DW-1:0]     data_q [LINES];
    cache_pkg::par_t   par_q  [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
            par_q[wr_idx]  <= wr_par;
        end else if (flip_en) begin
            data_q[flip_idx] <= data_q[flip_idx] ^ flip_mask;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_par   = par_q[rd_idx];

    AST_FLIP_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
        (flip_en && !wr_en) |=> (valid_q[$past(flip_idx)] == $past(valid_q[flip_idx]))) // R10
        else $error("injection altered a valid bit");
endmodule

// File: rtl/tag_check.sv
module tag_check #(
    parameter int TW = 8,
    parameter int DW = 32
) (
    input  logic             valid,
    input  logic [TW-1:0]    stored_tag,
    input  logic [TW-1:0]    req_tag,
    input  logic [DW-1:0]    data,
    input  cache_pkg::par_t  stored_par,
    output logic             hit,
    output logic             perr
);
    cache_pkg::par_t fresh_par;
    logic            tag_ok;

    par_gen #(.DW(DW)) u_par (
        .data (data),
        .par  (fresh_par)
    );

    always_comb begin
        tag_ok = valid && (stored_tag == req_tag);
        perr   = tag_ok && cache_pkg::par_mismatch(stored_par, fresh_par);
        hit    = tag_ok && !perr;
    end
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
    parameter int AW    = 12,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [AW-1:0]     cpu_addr,
    input  logic              look_hit,
    input  logic              look_perr,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic              resp_sel,
    output logic [DW-1:0]     resp_data,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_valid,
    output logic              fill_en,
    output logic [AW-1:0]     fill_addr,
    output logic [DW-1:0]     fill_data,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  perr_count
);
    import cache_pkg::*;

    fsm_e          state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] resp_q;
    logic          start_fill;

    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        cpu_hit    = 1'b0;
        resp_sel   = 1'b0;
        mem_req    = 1'b0;
        fill_en    = 1'b0;
        start_fill = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && look_hit) begin
                    cpu_ready = 1'b1;
                    cpu_hit   = 1'b1;
                end else if (cpu_req) begin
                    start_fill = 1'b1;
                    state_d    = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_valid) begin
                    fill_en = 1'b1;
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                resp_sel  = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            resp_q     <= '0;
            miss_count <= '0;
            perr_count <= '0;
        end else begin
            state_q <= state_d;
            if (start_fill) begin
                addr_q <= cpu_addr;
                if (look_perr) perr_count <= perr_count + 1'b1;
                else           miss_count <= miss_count + 1'b1;
            end
            if (fill_en) resp_q <= mem_rdata;
        end
    end

    assign mem_addr  = addr_q;
    assign fill_addr = addr_q;
    assign fill_data = mem_rdata;
    assign resp_data = resp_q;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))) // R2
        else $error("refill address not held");

    AST_PERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (perr_count != $past(perr_count)) |->
            ((perr_count == CNT_W'($past(perr_count) + 1'b1)) && (miss_count == $past(miss_count)))) // R5
        else $error("parity counter moved wrongly");

    AST_NO_READY_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready) // R3
        else $error("ready during refill");
endmodule

// File: rtl/parity_refill_cache.sv
module parity_refill_cache #(
    parameter int AW    = 12,
    parameter int IDX_W = 4,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [AW-1:0]     cpu_addr,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_valid,
    input  logic              flip_en,
    input  logic [IDX_W-1:0]  flip_idx,
    input  logic [DW-1:0]     flip_mask,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  perr_count
);
    localparam int TW = AW - IDX_W;

    logic              rd_valid;
    logic [TW-1:0]     rd_tag;
    logic [DW-1:0]     rd_data;
    cache_pkg::par_t   rd_par;
    cache_pkg::par_t   fill_par;
    logic              look_hit, look_perr;
    logic              resp_sel;
    logic [DW-1:0]     resp_data;
    logic              fill_en;
    logic [AW-1:0]     fill_addr;
    logic [DW-1:0]     fill_data;

    par_gen #(.DW(DW)) u_fill_par (
        .data (fill_data),
        .par  (fill_par)
    );

    line_store #(.IDX_W(IDX_W), .TW(TW), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (cpu_addr[IDX_W-1:0]),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .rd_par    (rd_par),
        .wr_en     (fill_en),
        .wr_idx    (fill_addr[IDX_W-1:0]),
        .wr_tag    (fill_addr[AW-1:IDX_W]),
        .wr_data   (fill_data),
        .wr_par    (fill_par),
        .flip_en   (flip_en),
        .flip_idx  (flip_idx),
        .flip_mask (flip_mask)
    );

    tag_check #(.TW(TW), .DW(DW)) u_check (
        .valid      (rd_valid),
        .stored_tag (rd_tag),
        .req_tag    (cpu_addr[AW-1:IDX_W]),
        .data       (rd_data),
        .stored_par (rd_par),
        .hit        (look_hit),
        .perr       (look_perr)
    );

    refill_ctrl #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .look_hit   (look_hit),
        .look_perr  (look_perr),
        .cpu_ready  (cpu_ready),
        .cpu_hit    (cpu_hit),
        .resp_sel   (resp_sel),
        .resp_data  (resp_data),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_valid  (mem_valid),
        .fill_en    (fill_en),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .miss_count (miss_count),
        .perr_count (perr_count)
    );

    assign cpu_rdata = resp_sel ? resp_data : rd_data;

    AST_REFILL_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid) |=> (cpu_ready && !cpu_hit && (cpu_rdata == $past(mem_rdata)))) // R3
        else $error("refill answer wrong");

    AST_NO_HIT_ON_PERR: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && look_perr) |-> !cpu_hit) // R5
        else $error("hit reported on parity error");

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |=> !mem_req) // R4
        else $error("memory request after hit");
endmodule

// File: tb/parity_refill_cache_test.sv
module parity_refill_cache_test;
    localparam int AW    = 12;
    localparam int IDX_W = 4;
    localparam int DW    = 32;
    localparam int CNT_W = 16;
    localparam int LAT   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic [AW-1:0]     cpu_addr = '0;
    logic [DW-1:0]     cpu_rdata;
    logic              cpu_ready, cpu_hit;
    logic              mem_req;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_rdata = '0;
    logic              mem_valid = 1'b0;
    logic              flip_en = 1'b0;
    logic [IDX_W-1:0]  flip_idx = '0;
    logic [DW-1:0]     flip_mask = '0;
    logic [CNT_W-1:0]  miss_count, perr_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  n_memreq = 0;
    int  n_addr_err = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    parity_refill_cache #(.AW(AW), .IDX_W(IDX_W), .DW(DW), .CNT_W(CNT_W)) uut (
        .clk, .rst, .cpu_req, .cpu_addr, .cpu_rdata, .cpu_ready, .cpu_hit,
        .mem_req, .mem_addr, .mem_rdata, .mem_valid,
        .flip_en, .flip_idx, .flip_mask, .miss_count, .perr_count
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (DW'(a) * 32'h0001_0003) ^ 32'hC3A5_1E0F;
    endfunction

    // backing memory: fixed latency, one-cycle valid, tracks address stability
    initial begin
        int waited = 0;
        logic [AW-1:0] first_addr = '0;
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
            end else if (mem_req) begin
                if (waited == 0) begin
                    first_addr = mem_addr;
                    n_memreq++;
                end else if (mem_addr != first_addr) begin
                    n_addr_err++;
                end
                waited++;
                if (waited == LAT) begin
                    mem_rdata = mem_word(mem_addr);
                    mem_valid = 1'b1;
                    waited = 0;
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output logic h, output int lat);
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_addr = a;
        lat = 0;
        #1;
        while (!cpu_ready && lat < 100) begin
            @(negedge clk);
            #1;
            lat++;
        end
        d = cpu_rdata;
        h = cpu_hit;
        cpu_req = 1'b0;
    endtask

    task automatic inject(input logic [IDX_W-1:0] idx, input logic [DW-1:0] m);
        @(negedge clk);
        flip_en = 1'b1;
        flip_idx = idx;
        flip_mask = m;
        @(negedge clk);
        flip_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 ready", 64'(cpu_ready), 64'd0);
        check("R1 hit", 64'(cpu_hit), 64'd0);
        check("R1 mem_req", 64'(mem_req), 64'd0);
        check("R1 miss_count", 64'(miss_count), 64'd0);
        check("R1 perr_count", 64'(perr_count), 64'd0);
    endtask

    task automatic t_cold_miss();
        logic [DW-1:0] d; logic h; int lat; int r0;
        r0 = n_memreq;
        do_read(12'h013, d, h, lat);
        check("R2 refill issued", 64'(n_memreq - r0), 64'd1);
        check("R2 miss_count", 64'(miss_count), 64'd1);
        check("R2 address held", 64'(n_addr_err), 64'd0);
        check("R3 ready latency", 64'(lat), 64'(LAT + 1));
        check("R3 refill data", 64'(d), 64'(mem_word(12'h013)));
        check("R3 hit low", 64'(h), 64'd0);
    endtask

    task automatic t_hit();
        logic [DW-1:0] d; logic h; int lat; int r0;
        r0 = n_memreq;
        do_read(12'h013, d, h, lat);
        check("R4 same-cycle ready", 64'(lat), 64'd0);
        check("R4 hit", 64'(h), 64'd1);
        check("R4 data", 64'(d), 64'(mem_word(12'h013)));
        check("R4 no memory access", 64'(n_memreq - r0), 64'd0);
    endtask

    task automatic t_single_flip();
        logic [DW-1:0] d; logic h; int lat; int r0;
        inject(4'h3, 32'h0000_0020);
        r0 = n_memreq;
        do_read(12'h013, d, h, lat);
        check("R5 refill issued", 64'(n_memreq - r0), 64'd1);
        check("R5 hit low", 64'(h), 64'd0);
        check("R5 data repaired", 64'(d), 64'(mem_word(12'h013)));
        check("R5 perr_count", 64'(perr_count), 64'd1);
        check("R5 miss_count unchanged", 64'(miss_count), 64'd1);
        do_read(12'h013, d, h, lat);
        check("R8 hit after repair", 64'(h), 64'd1);
        check("R8 data after repair", 64'(d), 64'(mem_word(12'h013)));
    endtask

    task automatic t_adjacent_flip();
        logic [DW-1:0] d; logic h; int lat; int r0;
        inject(4'h3, 32'h0000_00C0);
        r0 = n_memreq;
        do_read(12'h013, d, h, lat);
        check("R6 refill issued", 64'(n_memreq - r0), 64'd1);
        check("R6 hit low", 64'(h), 64'd0);
        check("R6 data repaired", 64'(d), 64'(mem_word(12'h013)));
        check("R6 perr_count", 64'(perr_count), 64'd2);
        check("R6 miss_count unchanged", 64'(miss_count), 64'd1);
        do_read(12'h013, d, h, lat);
        check("R8 hit after adjacent repair", 64'(h), 64'd1);
    endtask

    task automatic t_same_group_flip();
        logic [DW-1:0] d; logic h; int lat; int r0;
        inject(4'h3, 32'h0000_0005);
        r0 = n_memreq;
        do_read(12'h013, d, h, lat);
        check("R7 undetected hit", 64'(h), 64'd1);
        check("R7 corrupted data", 64'(d), 64'(mem_word(12'h013) ^ 32'h5));
        check("R7 no refill", 64'(n_memreq - r0), 64'd0);
        check("R10 parity untouched", 64'(perr_count), 64'd2);
        inject(4'h3, 32'h0000_0005);
        do_read(12'h013, d, h, lat);
        check("R10 mask restores word", 64'(d), 64'(mem_word(12'h013)));
        check("R10 still valid", 64'(h), 64'd1);
    endtask

    task automatic t_conflict();
        logic [DW-1:0] d; logic h; int lat;
        do_read(12'h023, d, h, lat);
        check("R9 conflict miss", 64'(h), 64'd0);
        check("R9 conflict data", 64'(d), 64'(mem_word(12'h023)));
        do_read(12'h013, d, h, lat);
        check("R9 evicted line misses", 64'(h), 64'd0);
        check("R9 miss_count", 64'(miss_count), 64'd3);
        do_read(12'h013, d, h, lat);
        check("R9 reloaded line hits", 64'(h), 64'd1);
    endtask

    initial begin
        t_reset();
        t_cold_miss();
        t_hit();
        t_single_flip();
        t_adjacent_flip();
        t_same_group_flip();
        t_conflict();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule